// File: doc/BRIEF.md
# Event-Driven Fully Connected Neuron Layer

This block is one layer of neurons, all fully connected to a set of inputs, that works on sparse events instead of a dense matrix-vector pass. A producer sends tagged input events. An activation event names one input and carries a non-negative graded value. For every neuron in parallel, the block multiplies that value by the neuron's 4-bit signed weight for that input, scales the product by the layer's power-of-two factor, and adds it to the neuron's saturating 16-bit state. A synchronization event closes the time step. The layer then stops taking input and scans its neurons from the lowest index upward. It emits one graded output event for each neuron whose state is positive and above the programmable threshold. After the scan, every state is reloaded with its bias for the next time step.

Weights, biases, the threshold and the shift are held in registers and written through a one-cycle configuration port. Output events leave on a valid/ready handshake as a neuron index with its value. A downstream stage can stall the scan without losing or reordering events.

Top module: `evfc_layer`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0, and every state, weight, bias, the threshold and the shift are 0.
- R2: An accepted activation event (in_valid=1, in_ready=1, in_is_sync=0) adds (in_value × weight[in_index][n]) << shift to the state of every neuron n in the clock edge that accepts it.
- R3: A state saturates at +32767 and -32768 and never wraps, including across repeated events.
- R4: An accepted synchronization event (in_is_sync=1) drops in_ready from the next cycle. The layer then visits neurons 0 to N_OUT-1 in ascending order, spending one cycle on a neuron that does not fire. A neuron that fires holds until the handshake. Events offered while in_ready is 0 are not taken.
- R5: During the scan, a neuron is emitted with out_value equal to its state exactly when the state is greater than 0 and greater than the signed threshold. No other neuron is emitted.
- R6: While out_valid is 1 and out_ready is 0, out_valid, out_index and out_value stay unchanged.
- R7: In the cycle after the last neuron is handled, every state equals its bias and in_ready is 1 again.
- R8: With cfg_we=1, cfg_sel selects the target. 0 writes a weight: address = input×N_OUT + neuron, data bits [3:0] are a signed value. 1 writes the bias of the neuron at the address, taking all 16 data bits, and loads that neuron's state at once. 2 writes the signed 16-bit threshold. 3 writes the shift from data bits [2:0].
- R9: The shift value s scales each product by 2^s before accumulation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input event offered |
| in_ready | output | 1 | Layer accepts input (low during the scan) |
| in_is_sync | input | 1 | 1: end-of-time-step event, 0: activation event |
| in_index | input | 4 | Presynaptic input index |
| in_value | input | 8 | Unsigned graded activation value |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target select |
| cfg_addr | input | 7 | Weight or neuron address |
| cfg_data | input | 16 | Configuration data |
| out_valid | output | 1 | Output event valid |
| out_ready | input | 1 | Downstream accepts output event |
| out_index | output | 3 | Index of the emitting neuron |
| out_value | output | 16 | Graded output value (state of the neuron) |

## Verification
A wrong state value stays hidden until the next synchronization event. It then shows as a missing, extra or wrong-valued output event on the first scan cycle that visits that neuron. A state that was not reloaded with its bias shows only in the scan that follows the next time step. A scan pointer or phase fault shows at once as an in_ready level that differs from the expected one, or as an out-of-order index. For these reasons the bench compares in_ready, out_valid, out_index and out_value against a behavioural model on every clock. It also runs back-to-back time steps so that faults carried from one step into the next are exposed.

// File: rtl/evfc_pkg.sv
package evfc_pkg;
  typedef enum logic {PH_RUN = 1'b0, PH_EMIT = 1'b1} phase_t;

  localparam logic [1:0] CFG_WEIGHT = 2'd0;
  localparam logic [1:0] CFG_BIAS   = 2'd1;
  localparam logic [1:0] CFG_THR    = 2'd2;
  localparam logic [1:0] CFG_SHIFT  = 2'd3;
endpackage

// File: rtl/evfc_param_store.sv
module evfc_param_store
  import evfc_pkg::*;
#(
  parameter int N_IN    = 16,
  parameter int N_OUT   = 8,
  parameter int W_BITS  = 4,
  parameter int S_BITS  = 16,
  parameter int SH_BITS = 3,
  localparam int IDX_W  = (N_IN > 1) ? $clog2(N_IN) : 1,
  localparam int ADDR_W = $clog2(N_IN * N_OUT)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [1:0]                cfg_sel,
  input  logic [ADDR_W-1:0]         cfg_addr,
  input  logic [S_BITS-1:0]         cfg_data,
  input  logic [IDX_W-1:0]          rd_idx,
  output logic [N_OUT*W_BITS-1:0]   w_row,
  output logic [N_OUT*S_BITS-1:0]   bias_flat,
  output logic [N_OUT-1:0]          bias_we,
  output logic [S_BITS-1:0]         thr,
  output logic [SH_BITS-1:0]        shift
);
  localparam int N_W = N_IN * N_OUT;

  logic [W_BITS-1:0]  w_q [N_W];
  logic [S_BITS-1:0]  bias_q [N_OUT];
  logic [S_BITS-1:0]  thr_q;
  logic [SH_BITS-1:0] sh_q;
  logic               w_en, thr_en, sh_en;
  logic [ADDR_W-1:0]  rd_base;

  always_comb begin
    w_en    = cfg_we && (cfg_sel == CFG_WEIGHT) && (int'(cfg_addr) < N_W);
    thr_en  = cfg_we && (cfg_sel == CFG_THR);
    sh_en   = cfg_we && (cfg_sel == CFG_SHIFT);
    rd_base = ADDR_W'(int'(rd_idx) * N_OUT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N_W; k++) w_q[k] <= '0;
    end else if (w_en) begin
      w_q[cfg_addr] <= cfg_data[W_BITS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) thr_q <= '0;
    else if (thr_en) thr_q <= cfg_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else if (sh_en) sh_q <= cfg_data[SH_BITS-1:0];
  end

  for (genvar n = 0; n < N_OUT; n++) begin : g_neu
    always_comb begin
      bias_we[n] = cfg_we && (cfg_sel == CFG_BIAS) && (cfg_addr == ADDR_W'(n));
      w_row[n*W_BITS +: W_BITS]    = w_q[rd_base + ADDR_W'(n)];
      bias_flat[n*S_BITS +: S_BITS] = bias_q[n];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bias_q[n] <= '0;
      else if (bias_we[n]) bias_q[n] <= cfg_data;
    end
  end

  assign thr   = thr_q;
  assign shift = sh_q;
endmodule

// File: rtl/evfc_neuron_array.sv
module evfc_neuron_array #(
  parameter int N_OUT   = 8,
  parameter int W_BITS  = 4,
  parameter int V_BITS  = 8,
  parameter int S_BITS  = 16,
  parameter int SH_BITS = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      acc_en,
  input  logic [V_BITS-1:0]         in_value,
  input  logic [N_OUT*W_BITS-1:0]   w_row,
  input  logic [SH_BITS-1:0]        shift,
  input  logic                      clear_all,
  input  logic [N_OUT*S_BITS-1:0]   bias_flat,
  input  logic [N_OUT-1:0]          bias_we,
  input  logic [S_BITS-1:0]         cfg_bias,
  output logic [N_OUT*S_BITS-1:0]   state_flat
);
  localparam int P_W   = V_BITS + W_BITS + 1;
  localparam int RAW_W = P_W + 2**SH_BITS;
  localparam int SUM_W = (RAW_W > S_BITS + 2) ? RAW_W : S_BITS + 2;
  localparam logic signed [SUM_W-1:0] SAT_HI = SUM_W'((2**(S_BITS-1)) - 1);
  localparam logic signed [SUM_W-1:0] SAT_LO = -SAT_HI - SUM_W'(1);

  for (genvar n = 0; n < N_OUT; n++) begin : g_neu
    logic signed [S_BITS-1:0] st_q, st_d;
    logic signed [P_W-1:0]    w_ext, v_ext, prod;
    logic signed [SUM_W-1:0]  scaled, sum;
    logic signed [S_BITS-1:0] sat_v;
    logic                     st_en;

    always_comb begin
      w_ext  = {{(P_W-W_BITS){w_row[n*W_BITS+W_BITS-1]}}, w_row[n*W_BITS +: W_BITS]};
      v_ext  = {{(P_W-V_BITS){1'b0}}, in_value};
      prod   = w_ext * v_ext;
      scaled = {{(SUM_W-P_W){prod[P_W-1]}}, prod} <<< shift;
      sum    = scaled + {{(SUM_W-S_BITS){st_q[S_BITS-1]}}, st_q};
      if (sum > SAT_HI)      sat_v = SAT_HI[S_BITS-1:0];
      else if (sum < SAT_LO) sat_v = SAT_LO[S_BITS-1:0];
      else                   sat_v = sum[S_BITS-1:0];
    end

    always_comb begin
      st_en = clear_all || bias_we[n] || acc_en;
      if (clear_all)       st_d = bias_flat[n*S_BITS +: S_BITS];
      else if (bias_we[n]) st_d = cfg_bias;
      else                 st_d = sat_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= '0;
      else if (st_en) st_q <= st_d;
    end

    assign state_flat[n*S_BITS +: S_BITS] = st_q;
  end
endmodule

// File: rtl/evfc_emit_ctrl.sv
module evfc_emit_ctrl
  import evfc_pkg::*;
#(
  parameter int N_OUT  = 8,
  parameter int S_BITS = 16,
  localparam int NEU_W = (N_OUT > 1) ? $clog2(N_OUT) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic                     in_is_sync,
  output logic                     in_ready,
  output logic                     acc_en,
  input  logic [N_OUT*S_BITS-1:0]  state_flat,
  input  logic [S_BITS-1:0]        thr,
  input  logic                     out_ready,
  output logic                     out_valid,
  output logic [NEU_W-1:0]         out_index,
  output logic [S_BITS-1:0]        out_value,
  output logic                     clear_all
);
  phase_t                   ph_q, ph_d;
  logic [NEU_W-1:0]         ptr_q, ptr_d;
  logic signed [S_BITS-1:0] cur;
  logic                     fire, step, last, sync_acc, ctl_en;

  always_comb begin
    cur      = state_flat[ptr_q*S_BITS +: S_BITS];
    in_ready = (ph_q == PH_RUN);
    acc_en   = in_valid && in_ready && !in_is_sync;
    sync_acc = in_valid && in_ready && in_is_sync;
    fire     = (ph_q == PH_EMIT) && (cur > $signed(thr)) && (cur > 0);
    step     = (ph_q == PH_EMIT) && (!fire || out_ready);
    last     = (ptr_q == NEU_W'(N_OUT - 1));
    clear_all = step && last;

    ph_d  = ph_q;
    ptr_d = ptr_q;
    if (sync_acc) begin
      ph_d  = PH_EMIT;
      ptr_d = '0;
    end else if (step) begin
      if (last) ph_d = PH_RUN;
      else      ptr_d = ptr_q + NEU_W'(1);
    end
    ctl_en = sync_acc || step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_RUN;
      ptr_q <= '0;
    end else if (ctl_en) begin
      ph_q  <= ph_d;
      ptr_q <= ptr_d;
    end
  end

  assign out_valid = fire;
  assign out_index = ptr_q;
  assign out_value = cur;
endmodule

// File: rtl/evfc_layer.sv
module evfc_layer #(
  parameter int N_IN    = 16,
  parameter int N_OUT   = 8,
  parameter int W_BITS  = 4,
  parameter int V_BITS  = 8,
  parameter int S_BITS  = 16,
  parameter int SH_BITS = 3,
  localparam int IDX_W  = (N_IN > 1) ? $clog2(N_IN) : 1,
  localparam int NEU_W  = (N_OUT > 1) ? $clog2(N_OUT) : 1,
  localparam int ADDR_W = $clog2(N_IN * N_OUT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_is_sync,
  input  logic [IDX_W-1:0]  in_index,
  input  logic [V_BITS-1:0] in_value,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [S_BITS-1:0] cfg_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [NEU_W-1:0]  out_index,
  output logic [S_BITS-1:0] out_value
);
  logic [N_OUT*W_BITS-1:0] w_row;
  logic [N_OUT*S_BITS-1:0] bias_flat, state_flat;
  logic [N_OUT-1:0]        bias_we;
  logic [S_BITS-1:0]       thr_cur;
  logic [SH_BITS-1:0]      shift_cur;
  logic                    acc_en, clear_all;

  evfc_param_store #(
    .N_IN(N_IN), .N_OUT(N_OUT), .W_BITS(W_BITS), .S_BITS(S_BITS), .SH_BITS(SH_BITS)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .rd_idx(in_index), .w_row(w_row), .bias_flat(bias_flat),
    .bias_we(bias_we), .thr(thr_cur), .shift(shift_cur)
  );

  evfc_neuron_array #(
    .N_OUT(N_OUT), .W_BITS(W_BITS), .V_BITS(V_BITS), .S_BITS(S_BITS), .SH_BITS(SH_BITS)
  ) u_neurons (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .in_value(in_value), .w_row(w_row),
    .shift(shift_cur), .clear_all(clear_all), .bias_flat(bias_flat), .bias_we(bias_we),
    .cfg_bias(cfg_data), .state_flat(state_flat)
  );

  evfc_emit_ctrl #(
    .N_OUT(N_OUT), .S_BITS(S_BITS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_is_sync(in_is_sync),
    .in_ready(in_ready), .acc_en(acc_en), .state_flat(state_flat), .thr(thr_cur),
    .out_ready(out_ready), .out_valid(out_valid), .out_index(out_index),
    .out_value(out_value), .clear_all(clear_all)
  );
endmodule

// File: rtl/evfc_layer_chk.sv
module evfc_layer_chk #(
  parameter int S_BITS = 16,
  parameter int NEU_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_is_sync,
  input logic              out_valid,
  input logic              out_ready,
  input logic [NEU_W-1:0]  out_index,
  input logic [S_BITS-1:0] out_value,
  input logic [S_BITS-1:0] thr
);
  // R4: no input is taken while an output event is pending
  p_no_input_while_emit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R4: an accepted synchronization event closes the input side
  p_sync_closes_input_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_is_sync) |=> !in_ready);

  // R4: indices leave in strictly ascending order within a scan
  p_ascending_index_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid || (out_index > $past(out_index))));

  // R5: only positive values above the threshold are emitted
  p_value_above_thr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (($signed(out_value) > $signed(thr)) && ($signed(out_value) > 0)));

  // R6: a stalled event is held unchanged
  p_hold_on_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_index) && $stable(out_value)));
endmodule

bind evfc_layer evfc_layer_chk #(.S_BITS(S_BITS), .NEU_W(NEU_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_is_sync(in_is_sync), .out_valid(out_valid), .out_ready(out_ready),
  .out_index(out_index), .out_value(out_value), .thr(thr_cur)
);

// File: tb/evfc_layer_bench.sv
module evfc_layer_bench;
  localparam int N_IN = 16, N_OUT = 8;

  logic        clk, rst_n;
  logic        in_valid, in_ready, in_is_sync;
  logic [3:0]  in_index;
  logic [7:0]  in_value;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [6:0]  cfg_addr;
  logic [15:0] cfg_data;
  logic        out_valid, out_ready;
  logic [2:0]  out_index;
  logic [15:0] out_value;

  evfc_layer u_evfc_layer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_is_sync(in_is_sync), .in_index(in_index), .in_value(in_value),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_index(out_index),
    .out_value(out_value)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int  mw [N_IN][N_OUT];
  int  mb [N_OUT];
  int  ms [N_OUT];
  int  mthr, msh, mptr;
  bit  memit;

  function automatic int sat(input int x);
    if (x > 32767) return 32767;
    if (x < -32768) return -32768;
    return x;
  endfunction

  function automatic bit fires(input int n);
    return (ms[n] > mthr) && (ms[n] > 0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mw[i, j]) mw[i][j] = 0;
      foreach (mb[j]) begin mb[j] = 0; ms[j] = 0; end
      mthr = 0; msh = 0; mptr = 0; memit = 0;
    end else begin
      bit clr;
      clr = 0;
      if (memit) begin
        if (!fires(mptr) || out_ready) begin
          if (mptr == N_OUT - 1) begin clr = 1; memit = 0; end
          else mptr++;
        end
      end else if (in_valid) begin
        if (in_is_sync) begin memit = 1; mptr = 0; end
        else for (int n = 0; n < N_OUT; n++)
          ms[n] = sat(ms[n] + ((int'(in_value) * mw[in_index][n]) <<< msh));
      end
      if (clr) for (int n = 0; n < N_OUT; n++) ms[n] = mb[n];
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: mw[int'(cfg_addr) / N_OUT][int'(cfg_addr) % N_OUT] = int'($signed(cfg_data[3:0]));
          2'd1: if (int'(cfg_addr) < N_OUT) begin
                  mb[cfg_addr] = int'($signed(cfg_data));
                  if (!clr) ms[cfg_addr] = int'($signed(cfg_data));
                end
          2'd2: mthr = int'($signed(cfg_data));
          default: msh = int'(cfg_data[2:0]);
        endcase
      end
    end
  end

  typedef struct { int idx; int val; } ev_t;
  ev_t log_q[$];

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit ev;
      ev = memit && fires(mptr);
      chk(in_ready == !memit, "R4", "in_ready", int'(in_ready), int'(!memit));
      chk(out_valid == ev, cur_req, "out_valid", int'(out_valid), int'(ev));
      if (ev && out_valid) begin
        chk(int'(out_index) == mptr, cur_req, "out_index", int'(out_index), mptr);
        chk(int'($signed(out_value)) == ms[mptr], cur_req, "out_value",
            int'($signed(out_value)), ms[mptr]);
      end
      if (out_valid && out_ready) log_q.push_back('{int'(out_index), int'($signed(out_value))});
    end
  end

  // ---------------- stimulus ----------------
  task automatic cfg(input logic [1:0] sel, input int addr, input int data);
    @(posedge clk); #1;
    cfg_we = 1; cfg_sel = sel; cfg_addr = 7'(addr); cfg_data = 16'(data);
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic send(input int idx, input int val, input bit sync);
    @(posedge clk); #1;
    in_valid = 1; in_index = 4'(idx); in_value = 8'(val); in_is_sync = sync;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk); #1;
    in_valid = 0; in_is_sync = 0;
  endtask

  task automatic finish_step();
    do @(negedge clk); while (!in_ready);
  endtask

  task automatic step_sync();
    log_q.delete();
    send(0, 0, 1);
    finish_step();
  endtask

  task automatic chk_ev(input string req, input int k, input int idx, input int val);
    if (log_q.size() > k) begin
      chk(log_q[k].idx == idx, req, "event index", log_q[k].idx, idx);
      chk(log_q[k].val == val, req, "event value", log_q[k].val, val);
    end else chk(0, req, "event missing", log_q.size(), k + 1);
  endtask

  initial begin
    rst_n = 0; in_valid = 0; in_is_sync = 0; in_index = 0; in_value = 0;
    cfg_we = 0; cfg_sel = 0; cfg_addr = 0; cfg_data = 0; out_ready = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    cur_req = "R1";
    chk(in_ready == 1, "R1", "in_ready after reset", int'(in_ready), 1);
    chk(out_valid == 0, "R1", "out_valid after reset", int'(out_valid), 0);
    step_sync();
    chk(log_q.size() == 0, "R1", "events from reset state", log_q.size(), 0);

    // R2 / R8: weights of input 3 are n-4
    cur_req = "R2";
    for (int n = 0; n < N_OUT; n++) cfg(2'd0, 3 * N_OUT + n, (n - 4) & 15);
    send(3, 10, 0);
    step_sync();
    chk(log_q.size() == 3, "R2", "event count", log_q.size(), 3);
    chk_ev("R2", 0, 5, 10); chk_ev("R2", 1, 6, 20); chk_ev("R2", 2, 7, 30);

    // R9 / R5: shift 2 and threshold 50
    cur_req = "R9";
    cfg(2'd3, 0, 2);
    cfg(2'd2, 0, 50);
    send(3, 10, 0);
    step_sync();
    chk(log_q.size() == 2, "R5", "event count above threshold", log_q.size(), 2);
    chk_ev("R9", 0, 6, 80); chk_ev("R9", 1, 7, 120);

    // R8 / R7: bias write loads the state and is restored after each scan
    cur_req = "R8";
    cfg(2'd1, 2, 500);
    step_sync();
    chk(log_q.size() == 1, "R8", "bias event count", log_q.size(), 1);
    chk_ev("R8", 0, 2, 500);
    cur_req = "R7";
    step_sync();
    chk(log_q.size() == 1, "R7", "state back to bias", log_q.size(), 1);
    chk_ev("R7", 0, 2, 500);
    cfg(2'd1, 2, 0);

    // R3: saturation in both directions, repeated events
    cur_req = "R3";
    cfg(2'd3, 0, 7);
    cfg(2'd2, 0, 0);
    cfg(2'd0, 0, 7);
    cfg(2'd0, 1, 8);
    send(0, 255, 0);
    send(0, 255, 0);
    step_sync();
    chk(log_q.size() == 1, "R3", "saturated event count", log_q.size(), 1);
    chk_ev("R3", 0, 0, 32767);

    // R7 / R4: empty step, nothing fires, scan lasts N_OUT cycles
    cur_req = "R7";
    log_q.delete();
    send(0, 0, 1);
    begin
      int low = 0;
      do begin @(negedge clk); if (!in_ready) low++; end while (!in_ready);
      chk(low == N_OUT, "R4", "scan length in cycles", low, N_OUT);
    end
    chk(log_q.size() == 0, "R7", "states cleared to zero bias", log_q.size(), 0);

    // R6: stalled output handshake
    cur_req = "R6";
    cfg(2'd3, 0, 0);
    send(3, 10, 0);
    log_q.delete();
    fork
      send(0, 0, 1);
      for (int c = 0; c < 24; c++) begin
        @(posedge clk); #1 out_ready = (c % 3 == 2);
      end
    join
    @(posedge clk); #1 out_ready = 1;
    finish_step();
    chk(log_q.size() == 3, "R6", "events under stall", log_q.size(), 3);
    chk_ev("R6", 0, 5, 10); chk_ev("R6", 1, 6, 20); chk_ev("R6", 2, 7, 30);

    // R4: event offered during the scan is taken only afterwards, once
    cur_req = "R4";
    send(0, 0, 1);
    send(3, 1, 0);
    step_sync();
    chk(log_q.size() == 3, "R4", "held-off event count", log_q.size(), 3);
    chk_ev("R4", 0, 5, 1); chk_ev("R4", 1, 6, 2); chk_ev("R4", 2, 7, 3);

    repeat (4) @(posedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      chk(0, "R4", "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule